// File: doc/BRIEF.md
# Bang-Bang Clock Recovery Loop

This block is the digital loop of a clock-and-data-recovery receiver that takes two samples per symbol. The first is a data sample taken at the centre of the eye. The second is an edge sample taken at the symbol boundary. Both arrive already sliced to single bits. The block keeps the previous data bit. It compares the previous bit, the current bit and the edge sample that lies between them, and from that it decides whether the sampling clock runs early or late. No decision is made when the data does not change.

Votes pass through a first-order filter. This is a signed accumulator with a programmable threshold, and it sets the loop gain. When the filter reaches the threshold in either direction, the phase-select index moves by one step and the accumulator clears. The index has no frequency integrator. It counts modulo 2^PHASE_BITS (256 steps by default) and drives an external phase interpolator.

Samples enter on a valid/ready stream. The recovered data bit leaves on a one-entry valid/ready output stream. A sample is consumed only when `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle, so a stall at the output stops intake and freezes the loop. Two counters of early and late votes are provided for debug.

Top module: `bbcdr_loop`

## Requirements
- R1: While `rst` is high at a clock edge, the following happens after that edge: `phase_code` loads `init_phase`, the stored previous bit becomes 0, the accumulator clears, both vote counters read 0, and `out_valid` is 0.
- R2: An accepted sample whose data bit equals the stored previous bit gives no vote. `phase_code` and both counters stay unchanged.
- R3: An accepted sample whose data bit differs from the previous bit, with the edge sample equal to the previous bit, is an early vote. With POLARITY=0 and a threshold of 1, `phase_code` rises by one at the accepting edge.
- R4: An accepted sample whose data bit differs from the previous bit, with the edge sample equal to the new data bit, is a late vote. With POLARITY=0 and a threshold of 1, `phase_code` falls by one at the accepting edge.
- R5: `phase_code` changes by at most one step per cycle and wraps modulo 2^PHASE_BITS: 255 plus one gives 0, and 0 minus one gives 255.
- R6: With threshold T, an early vote adds +1 to the accumulator and a late vote adds -1. A step happens when the accumulator reaches +T (up) or -T (down), and the accumulator then clears to 0. `gain_thresh` = 0 acts as 1.
- R7: A sample is accepted only on a cycle with `in_valid` and `in_ready` both high. `in_ready` is low while `out_valid` is high and `out_ready` is low. `out_bit` carries the accepted data bit from the cycle after acceptance, and it stays stable until it is taken. `phase_code` does not move on a cycle with no acceptance.
- R8: `early_count` and `late_count` each increase by one for every early or late vote, and they wrap at 2^CNT_BITS.
- R9: The stored previous bit updates only on accepted samples. A stalled sample does not disturb the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_phase | input | PHASE_BITS | Phase index loaded on reset |
| gain_thresh | input | THR_BITS | Vote count needed per phase step (0 acts as 1) |
| in_valid | input | 1 | Sample pair valid |
| in_ready | output | 1 | Sample pair can be accepted |
| in_data | input | 1 | Sliced eye-centre data sample |
| in_edge | input | 1 | Sliced boundary sample between previous and current data |
| out_valid | output | 1 | Recovered bit valid |
| out_ready | input | 1 | Downstream takes recovered bit |
| out_bit | output | 1 | Recovered data bit |
| phase_code | output | PHASE_BITS | Phase-select index for the interpolator |
| early_count | output | CNT_BITS | Number of early votes |
| late_count | output | CNT_BITS | Number of late votes |

## Verification
Two functions can fall in the same cycle. The first is a phase step caused by a vote. The second is the modulo wrap of the index at its boundary. The bench resets the index to 255, sends an early vote and expects 0, then sends a late vote and expects 255. A second coincidence is a vote that arrives while the output is stalled. The bench holds `out_ready` low and presents a transition sample. It then confirms that the phase, the recovered bit and the history stay unchanged until the stall clears, and that the held vote takes effect on the releasing edge.

// File: rtl/bbcdr_pkg.sv
package bbcdr_pkg;
  typedef enum logic [1:0] {
    VOTE_NONE  = 2'd0,
    VOTE_EARLY = 2'd1,
    VOTE_LATE  = 2'd2
  } vote_e;
endpackage

// File: rtl/bbcdr_phase_detect.sv
module bbcdr_phase_detect
  import bbcdr_pkg::*;
(
  input  logic  cur_bit,
  input  logic  prev_bit,
  input  logic  edge_s,
  output vote_e vote
);
  // A transition is needed for timing information; the boundary sample
  // siding with the old bit means the clock samples too early.
  always_comb begin
    if (cur_bit == prev_bit)    vote = VOTE_NONE;
    else if (edge_s == prev_bit) vote = VOTE_EARLY;
    else                         vote = VOTE_LATE;
  end
endmodule

// File: rtl/bbcdr_vote_filter.sv
module bbcdr_vote_filter
  import bbcdr_pkg::*;
#(
  parameter int THR_BITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  vote_e               vote,
  input  logic [THR_BITS-1:0] thresh,
  output logic                step_up,
  output logic                step_dn
);
  localparam int ACC_W = THR_BITS + 1;

  logic signed [ACC_W-1:0] acc, acc_nxt, thr_pos, thr_neg;
  logic [THR_BITS-1:0]     thr_eff;

  always_comb begin
    thr_eff = (thresh == '0) ? THR_BITS'(1) : thresh;
    thr_pos = $signed({1'b0, thr_eff});
    thr_neg = -thr_pos;
    acc_nxt = acc;
    if (en && vote == VOTE_EARLY) acc_nxt = acc + ACC_W'(1);
    if (en && vote == VOTE_LATE)  acc_nxt = acc - ACC_W'(1);
    step_up = en && (vote == VOTE_EARLY) && (acc_nxt >= thr_pos);
    step_dn = en && (vote == VOTE_LATE)  && (acc_nxt <= thr_neg);
  end

  always_ff @(posedge clk) begin
    if (rst)                     acc <= '0;
    else if (step_up || step_dn) acc <= '0;
    else                         acc <= acc_nxt;
  end
endmodule

// File: rtl/bbcdr_phase_acc.sv
module bbcdr_phase_acc #(
  parameter int PHASE_BITS = 8,
  parameter bit POLARITY   = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PHASE_BITS-1:0] init_phase,
  input  logic                  step_up,
  input  logic                  step_dn,
  output logic [PHASE_BITS-1:0] phase
);
  logic inc, dec;

  generate
    if (POLARITY) begin : g_inv
      assign inc = step_dn;
      assign dec = step_up;
    end else begin : g_dir
      assign inc = step_up;
      assign dec = step_dn;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)      phase <= init_phase;
    else if (inc) phase <= phase + PHASE_BITS'(1);
    else if (dec) phase <= phase - PHASE_BITS'(1);
  end
endmodule

// File: rtl/bbcdr_event_cnt.sv
module bbcdr_event_cnt #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [WIDTH-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + WIDTH'(1);
  end
endmodule

// File: rtl/bbcdr_loop.sv
module bbcdr_loop
  import bbcdr_pkg::*;
#(
  parameter int PHASE_BITS = 8,
  parameter int THR_BITS   = 4,
  parameter int CNT_BITS   = 16,
  parameter bit POLARITY   = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PHASE_BITS-1:0] init_phase,
  input  logic [THR_BITS-1:0]   gain_thresh,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_data,
  input  logic                  in_edge,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  out_bit,
  output logic [PHASE_BITS-1:0] phase_code,
  output logic [CNT_BITS-1:0]   early_count,
  output logic [CNT_BITS-1:0]   late_count
);
  logic  fire, hist, step_up, step_dn;
  vote_e vote;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)       hist <= 1'b0;
    else if (fire) hist <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_bit   <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  bbcdr_phase_detect u_pd (
    .cur_bit (in_data),
    .prev_bit(hist),
    .edge_s  (in_edge),
    .vote    (vote)
  );

  bbcdr_vote_filter #(.THR_BITS(THR_BITS)) u_filt (
    .clk    (clk),
    .rst    (rst),
    .en     (fire),
    .vote   (vote),
    .thresh (gain_thresh),
    .step_up(step_up),
    .step_dn(step_dn)
  );

  bbcdr_phase_acc #(.PHASE_BITS(PHASE_BITS), .POLARITY(POLARITY)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .init_phase(init_phase),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .phase     (phase_code)
  );

  bbcdr_event_cnt #(.WIDTH(CNT_BITS)) u_cnt_early (
    .clk  (clk),
    .rst  (rst),
    .inc  (fire && vote == VOTE_EARLY),
    .count(early_count)
  );

  bbcdr_event_cnt #(.WIDTH(CNT_BITS)) u_cnt_late (
    .clk  (clk),
    .rst  (rst),
    .inc  (fire && vote == VOTE_LATE),
    .count(late_count)
  );
endmodule

// File: rtl/bbcdr_loop_chk.sv
module bbcdr_loop_chk #(
  parameter int PHASE_BITS = 8,
  parameter int CNT_BITS   = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  fire,
  input logic                  in_data,
  input logic                  hist,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic                  out_bit,
  input logic [PHASE_BITS-1:0] init_phase,
  input logic [PHASE_BITS-1:0] phase_code,
  input logic [CNT_BITS-1:0]   early_count
);
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  p_reset_load_r1: assert property (@(posedge clk)
    primed && $past(rst) |-> phase_code == $past(init_phase) && early_count == '0 && !out_valid);

  p_no_trans_hold_r2: assert property (@(posedge clk) disable iff (rst)
    fire && (in_data == hist) |=> $stable(phase_code));

  p_unit_step_r5: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) |->
      (phase_code == $past(phase_code) ||
       phase_code == PHASE_BITS'($past(phase_code) + 1'b1) ||
       phase_code == PHASE_BITS'($past(phase_code) - 1'b1)));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && !$past(fire) |-> $stable(phase_code));

  p_stall_ready_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_bit));

  p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) |->
      (early_count == $past(early_count) ||
       early_count == CNT_BITS'($past(early_count) + 1'b1)));
endmodule

bind bbcdr_loop bbcdr_loop_chk #(.PHASE_BITS(PHASE_BITS), .CNT_BITS(CNT_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fire       (fire),
  .in_data    (in_data),
  .hist       (hist),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_bit    (out_bit),
  .init_phase (init_phase),
  .phase_code (phase_code),
  .early_count(early_count)
);

// File: tb/bbcdr_loop_tb.sv
module bbcdr_loop_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] init_phase = 8'd100;
  logic [3:0] gain_thresh = 4'd1;
  logic       in_valid = 1'b0, in_data = 1'b0, in_edge = 1'b0, out_ready = 1'b1;
  logic       in_ready, out_valid, out_bit;
  logic [7:0] phase_code;
  logic [15:0] early_count, late_count;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  bbcdr_loop u_dut (
    .clk(clk), .rst(rst), .init_phase(init_phase), .gain_thresh(gain_thresh),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_edge(in_edge),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .phase_code(phase_code), .early_count(early_count), .late_count(late_count)
  );

  // entries {data, edge, vote}; vote 0 none, 1 early, 2 late (from prev bit 0)
  localparam logic [3:0] VEC [10] = '{
    4'b0100, 4'b1001, 4'b1100, 4'b0010, 4'b1110,
    4'b0101, 4'b0000, 4'b1001, 4'b0101, 4'b1110
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] ip, input logic [3:0] th);
    @(negedge clk);
    rst = 1'b1; init_phase = ip; gain_thresh = th; in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(input logic d, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_edge = e;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int exp_ph;
    do_reset(8'd100, 4'd1);
    chk("R1 phase after reset", phase_code, 100);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 early_count after reset", early_count, 0);
    chk("R1 late_count after reset", late_count, 0);

    // table walk: R2 R3 R4 R9
    exp_ph = 100;
    for (int i = 0; i < 10; i++) begin
      send(VEC[i][3], VEC[i][2]);
      if (VEC[i][1:0] == 2'd1) exp_ph++;
      if (VEC[i][1:0] == 2'd2) exp_ph--;
      chk($sformatf("R3/R4/R2 phase vec %0d", i), phase_code, exp_ph);
      chk($sformatf("R7 out_bit vec %0d", i), out_bit, VEC[i][3]);
    end
    chk("R8 early_count", early_count, 4);
    chk("R8 late_count", late_count, 3);

    // R5 wrap both ways
    do_reset(8'd255, 4'd1);
    send(1'b1, 1'b0);
    chk("R5 wrap up", phase_code, 0);
    send(1'b0, 1'b0);
    chk("R5 wrap down", phase_code, 255);

    // R6 threshold 3 with cancellation and clear
    do_reset(8'd50, 4'd3);
    send(1'b1, 1'b0);
    send(1'b0, 1'b1);
    chk("R6 below threshold", phase_code, 50);
    send(1'b1, 1'b1);
    send(1'b0, 1'b1);
    chk("R6 late cancels", phase_code, 50);
    send(1'b1, 1'b0);
    chk("R6 step at threshold", phase_code, 51);
    send(1'b0, 1'b1);
    chk("R6 accumulator cleared", phase_code, 51);

    // R6 threshold zero acts as one
    do_reset(8'd10, 4'd0);
    send(1'b1, 1'b0);
    chk("R6 zero threshold", phase_code, 11);

    // R7 R9 back-pressure
    do_reset(8'd20, 4'd1);
    out_ready = 1'b0;
    send(1'b1, 1'b0);
    chk("R7 accepted phase", phase_code, 21);
    chk("R7 in_ready low in stall", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b1; in_data = 1'b0; in_edge = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 stalled phase held", phase_code, 21);
    chk("R7 stalled out_bit held", out_bit, 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 released vote applied", phase_code, 22);
    chk("R7 released out_bit", out_bit, 0);
    send(1'b0, 1'b1);
    chk("R9 history took released bit", phase_code, 22);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule